// File: doc/BRIEF.md
# Atomic Set/Clear Register Bank

This block holds a small bank of 32-bit shared control registers. Several bus masters can update these registers without a lock. Every register can be reached through three address windows. The plain window reads the register or replaces it whole. The set window turns on the bits that are 1 in the write data. The clear window turns off the bits that are 1 in the write data. A master that owns only some bits of a shared register can change them with a single write. No read-modify-write is needed, so another master's update to other bits is never lost.

Two independent requester ports reach the bank. Each port is a simple valid/ready memory-mapped port with a little-endian 32-bit data path. Both ports can be accepted in the same cycle. When both ports target the same register in one cycle, their updates are merged into a single next value. That merge follows a fixed rule: one plain value wins, then all set masks are applied, then all clear masks.

Top module: `atomic_bank`

## Requirements
- R1: A write to a mapped register in the plain window (address bits [13:12] = 0) replaces the whole register with the write data.
- R2: A write in the set window (address bits [13:12] = 1) ORs the write data into the register. Data bits that are 0 leave their register bits unchanged.
- R3: A write in the clear window (address bits [13:12] = 2) clears each register bit whose data bit is 1. Data bits that are 0 leave their register bits unchanged.
- R4: Every accepted request gets exactly one response, with rsp_valid high, in the cycle after acceptance. A read in any of the three windows returns the register's current value.
- R5: When a set and a clear reach the same register in one cycle, the set is applied first and the clear second. A bit named in both masks therefore ends at 0.
- R6: Set masks that reach one register from both ports in one cycle are OR-combined. Clear masks are OR-combined the same way. No update is dropped.
- R7: When both ports make a plain write to the same register in one cycle, port 0's data wins. Any same-cycle set or clear masks are then applied on top of that value, set before clear.
- R8: An access is unmapped when its window code is 3 or its word offset (address bits [11:2]) is 16 or more. An unmapped access responds with rsp_err = 1 and read data 0. It changes no register.
- R9: Address bits above bit 13 and address bits [1:0] are ignored by the decode.
- R10: While rst is high, all registers clear to zero and req_ready is low. After reset, both ports accept one request every cycle.
- R11: A read returns the register value from before any write accepted in the same cycle. Responses to writes carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle, one bit per port |
| req_write | input | NPORTS | 1 = write, 0 = read, one bit per port |
| req_addr | input | NPORTS x ADDR_W | Byte address: window code in [13:12], word offset in [11:2] |
| req_wdata | input | NPORTS x DATA_W | Write data or bit mask |
| rsp_valid | output | NPORTS | Response valid, one cycle after acceptance |
| rsp_err | output | NPORTS | Access hit an unmapped offset |
| rsp_rdata | output | NPORTS x DATA_W | Read data, 0 for writes and errors |

## Verification
The bench builds the bank with its default parameters: 16 registers, two ports and a 16-bit address. With these values the bench can reach address bits [15:14], which the decode must ignore. It can also use the offset 0x040, which lies just past the last register. A wrong decode that truncates the offset would alias that address onto register 0, and the bench checks that register 0 is left alone. Two ports make every same-cycle collision reachable: plain against plain, set against clear, and plain mixed with masks. A scripted phase covers each collision directly. A long random phase then mixes all windows on both ports against the scoreboard model.

// File: rtl/atomic_bank_pkg.sv
package atomic_bank_pkg;

    localparam int WIN_LSB  = 12;
    localparam int WIN_W    = 2;
    localparam int OFF_W    = 10;   // word offset bits [11:2]
    localparam int IDX_W    = 8;    // carried index width (bank <= 256 regs)
    localparam int DEC_AW   = WIN_LSB + WIN_W;

    typedef enum logic [WIN_W-1:0] {
        WIN_PLAIN = 2'd0,
        WIN_SET   = 2'd1,
        WIN_CLR   = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    typedef struct packed {
        logic             act;     // accepted this cycle
        logic             wr;
        win_e             win;
        logic             mapped;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_req(input logic valid, input logic ready,
                                        input logic wr,
                                        input logic [DEC_AW-1:0] addr,
                                        input int num_regs);
        dec_t             d;
        logic [OFF_W-1:0] off;
        off      = addr[WIN_LSB-1:2];
        d.act    = valid & ready;
        d.wr     = wr;
        d.win    = win_e'(addr[DEC_AW-1:WIN_LSB]);
        d.mapped = (d.win != WIN_NONE) && (int'(off) < num_regs);
        d.idx    = off[IDX_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/atomic_bank_port_dec.sv
module atomic_bank_port_dec
    import atomic_bank_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 16
) (
    input  logic              valid,
    input  logic              ready,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    // Bits above the window code and the byte lanes are not decoded (R9).
    always_comb begin
        dec = decode_req(valid, ready, write, addr[DEC_AW-1:0], NUM_REGS);
    end

endmodule

// File: rtl/atomic_bank_cell.sv
module atomic_bank_cell
    import atomic_bank_pkg::*;
#(
    parameter int NPORTS  = 2,
    parameter int DATA_W  = 32,
    parameter int REG_IDX = 0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  dec_t                           dec   [NPORTS],
    input  logic [NPORTS-1:0][DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]              q
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(REG_IDX);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] set_m;
    logic [DATA_W-1:0] clr_m;
    logic [DATA_W-1:0] nxt;
    logic [NPORTS-1:0] hit;
    logic [NPORTS-1:0] plain_hit;
    logic              touch;

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            hit[p]       = dec[p].act && dec[p].wr && dec[p].mapped &&
                           (dec[p].idx == MY_IDX);
            plain_hit[p] = hit[p] && (dec[p].win == WIN_PLAIN);
        end
        touch = |hit;
    end

    // Highest port first so the lowest index plain write ends on top (R7);
    // masks from every port are OR-combined (R6).
    always_comb begin
        base  = q;
        set_m = '0;
        clr_m = '0;
        for (int p = NPORTS - 1; p >= 0; p--) begin
            if (hit[p]) begin
                unique case (dec[p].win)
                    WIN_PLAIN: base  = wdata[p];
                    WIN_SET:   set_m = set_m | wdata[p];
                    WIN_CLR:   clr_m = clr_m | wdata[p];
                    default:   ;
                endcase
            end
        end
        nxt = (base | set_m) & ~clr_m;   // set first, clear last (R5)
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_m != '0) |=> ((q & $past(clr_m)) == '0)); // R5

    AST_SET_APPLIED: assert property (@(posedge clk) disable iff (rst)
        ((set_m & ~clr_m) != '0) |=>
            ((q & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m))); // R2

    AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !touch |=> $stable(q)); // R8

    AST_PORT0_PLAIN_WINS: assert property (@(posedge clk) disable iff (rst)
        (plain_hit[0] && set_m == '0 && clr_m == '0) |=> (q == $past(wdata[0]))); // R7

endmodule

// File: rtl/atomic_bank_resp.sv
module atomic_bank_resp
    import atomic_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] cur,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    // cur is the pre-update register value, so reads see old data (R11).
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= dec.act;
            rsp_err   <= dec.act && !dec.mapped;
            rsp_rdata <= (dec.act && !dec.wr && dec.mapped) ? cur : '0;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0)); // R8

    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dec.act |=> rsp_valid); // R4

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !dec.act |=> !rsp_valid); // R4

endmodule

// File: rtl/atomic_bank.sv
module atomic_bank
    import atomic_bank_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPORTS-1:0]              req_valid,
    output logic [NPORTS-1:0]              req_ready,
    input  logic [NPORTS-1:0]              req_write,
    input  logic [NPORTS-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NPORTS-1:0][DATA_W-1:0]  req_wdata,
    output logic [NPORTS-1:0]              rsp_valid,
    output logic [NPORTS-1:0]              rsp_err,
    output logic [NPORTS-1:0][DATA_W-1:0]  rsp_rdata
);

    localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    dec_t              dec  [NPORTS];
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DATA_W-1:0] cur  [NPORTS];

    // No back-pressure after reset; nothing accepted during reset (R10).
    assign req_ready = {NPORTS{~rst}};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        atomic_bank_port_dec #(
            .ADDR_W   (ADDR_W),
            .NUM_REGS (NUM_REGS)
        ) u_dec (
            .valid (req_valid[p]),
            .ready (req_ready[p]),
            .write (req_write[p]),
            .addr  (req_addr[p]),
            .dec   (dec[p])
        );

        assign cur[p] = regs[dec[p].idx[REG_W-1:0]];

        atomic_bank_resp #(
            .DATA_W (DATA_W)
        ) u_resp (
            .clk       (clk),
            .rst       (rst),
            .dec       (dec[p]),
            .cur       (cur[p]),
            .rsp_valid (rsp_valid[p]),
            .rsp_err   (rsp_err[p]),
            .rsp_rdata (rsp_rdata[p])
        );
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        atomic_bank_cell #(
            .NPORTS  (NPORTS),
            .DATA_W  (DATA_W),
            .REG_IDX (r)
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .dec   (dec),
            .wdata (req_wdata),
            .q     (regs[r])
        );
    end

endmodule

// File: tb/tb_atomic_bank.sv
module tb_atomic_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        req_valid = '0;
    logic [1:0]        req_ready;
    logic [1:0]        req_write = '0;
    logic [1:0][15:0]  req_addr  = '0;
    logic [1:0][31:0]  req_wdata = '0;
    logic [1:0]        rsp_valid;
    logic [1:0]        rsp_err;
    logic [1:0][31:0]  rsp_rdata;

    atomic_bank dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        err;
        logic [31:0] data;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb0[$];
    exp_t        sb1[$];
    logic [31:0] model [NREG];
    int          ncyc   = 0;
    int          checks = 0;
    int          errors = 0;

    localparam logic [15:0] PL = 16'h0000;
    localparam logic [15:0] ST = 16'h1000;
    localparam logic [15:0] CL = 16'h2000;

    always @(posedge clk) begin
        ncyc <= ncyc + 1;
        if (ncyc > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", ncyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check_port(input int p);
        exp_t e;
        bit   have;
        have = (p == 0) ? (sb0.size() > 0 && sb0[0].due == ncyc)
                        : (sb1.size() > 0 && sb1[0].due == ncyc);
        if (have) begin
            e = (p == 0) ? sb0.pop_front() : sb1.pop_front();
            checks = checks + 1;
            if (rsp_valid[p] !== 1'b1 || rsp_err[p] !== e.err || rsp_rdata[p] !== e.data) begin
                errors = errors + 1;
                $display("FAIL %s port%0d: actual v=%b err=%b data=%h expected v=1 err=%b data=%h",
                         e.tag, p, rsp_valid[p], rsp_err[p], rsp_rdata[p], e.err, e.data);
            end
        end else if (rsp_valid[p] !== 1'b0) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R4 spurious port%0d: actual rsp_valid=%b expected 0", p, rsp_valid[p]);
        end
    endtask

    // Monitor: compares responses against the scoreboard away from edges.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check_port(0);
            check_port(1);
        end
    end

    function automatic bit is_mapped(input logic [15:0] a);
        return (a[13:12] != 2'd3) && (int'(a[11:2]) < NREG);
    endfunction

    // Driver: applies one cycle on both ports, pushes expected responses,
    // then advances the reference model.
    task automatic go(input bit v0, input bit w0, input logic [15:0] a0, input logic [31:0] d0,
                      input bit v1, input bit w1, input logic [15:0] a1, input logic [31:0] d1,
                      input string tag);
        bit          v [2];
        bit          w [2];
        logic [15:0] a [2];
        logic [31:0] d [2];
        exp_t        e;
        v[0] = v0; w[0] = w0; a[0] = a0; d[0] = d0;
        v[1] = v1; w[1] = w1; a[1] = a1; d[1] = d1;
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            req_valid[p] = v[p];
            req_write[p] = w[p];
            req_addr[p]  = a[p];
            req_wdata[p] = d[p];
            if (v[p]) begin
                e.err  = !is_mapped(a[p]);
                e.data = (!w[p] && is_mapped(a[p])) ? model[int'(a[p][11:2])] : 32'h0;
                e.due  = ncyc + 1;
                e.tag  = tag;
                if (p == 0) sb0.push_back(e); else sb1.push_back(e);
            end
        end
        for (int r = 0; r < NREG; r++) begin
            logic [31:0] base, sm, cm;
            base = model[r]; sm = '0; cm = '0;
            for (int p = 1; p >= 0; p--) begin
                if (v[p] && w[p] && is_mapped(a[p]) && int'(a[p][11:2]) == r) begin
                    if (a[p][13:12] == 2'd0) base = d[p];
                    else if (a[p][13:12] == 2'd1) sm = sm | d[p];
                    else cm = cm | d[p];
                end
            end
            model[r] = (base | sm) & ~cm;
        end
    endtask

    task automatic idle();
        go(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    function automatic logic [15:0] ra(input logic [15:0] win, input int r);
        return win | 16'(r * 4);
    endfunction

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        checks = checks + 1;
        if (req_ready !== 2'b00) begin
            errors = errors + 1;
            $display("FAIL R10 ready in reset: actual=%b expected=00", req_ready);
        end
        rst = 1'b0;

        // R10: every register reads zero after reset
        for (int r = 0; r < NREG; r += 2)
            go(1, 0, ra(PL, r), 0, 1, 0, ra(PL, r + 1), 0, "R10 reset value");

        // R1 plain write, R11 same-cycle read sees old value
        go(1, 1, ra(PL, 3), 32'hA5A5_0F0F, 0, 0, 0, 0, "R1 plain write");
        go(1, 1, ra(PL, 5), 32'h0000_1234, 1, 0, ra(PL, 5), 0, "R11 read old value");
        go(1, 0, ra(PL, 3), 0, 1, 0, ra(PL, 5), 0, "R1 readback");

        // R2 set window, R4 read through set/clear windows
        go(0, 0, 0, 0, 1, 1, ra(ST, 3), 32'h0000_F000, "R2 set");
        go(1, 0, ra(ST, 3), 0, 0, 0, 0, 0, "R4 read via set window");
        // R3 clear window
        go(1, 1, ra(CL, 3), 32'hA500_0000, 0, 0, 0, 0, "R3 clear");
        go(0, 0, 0, 0, 1, 0, ra(CL, 3), 0, "R4 read via clear window");

        // R5 set and clear in one cycle, overlapping bits end cleared
        go(1, 1, ra(ST, 7), 32'h0000_00FF, 1, 1, ra(CL, 7), 32'h0000_000F, "R5 set then clear");
        go(1, 0, ra(PL, 7), 0, 0, 0, 0, 0, "R5 result");
        // R6 both ports set, then both clear
        go(1, 1, ra(ST, 8), 32'h0000_0001, 1, 1, ra(ST, 8), 32'h0000_0100, "R6 dual set");
        go(1, 0, ra(PL, 8), 0, 0, 0, 0, 0, "R6 dual set result");
        go(1, 1, ra(CL, 8), 32'h0000_0001, 1, 1, ra(CL, 8), 32'h0000_0100, "R6 dual clear");
        go(0, 0, 0, 0, 1, 0, ra(PL, 8), 0, "R6 dual clear result");

        // R7 plain collision and masks on top of winner
        go(1, 1, ra(PL, 9), 32'h0000_1111, 1, 1, ra(PL, 9), 32'h0000_2222, "R7 port0 wins");
        go(1, 0, ra(PL, 9), 0, 0, 0, 0, 0, "R7 result");
        go(1, 1, ra(PL, 9), 32'hFFFF_0000, 1, 1, ra(ST, 9), 32'h0000_000F, "R7 plain plus set");
        go(0, 0, 0, 0, 1, 0, ra(PL, 9), 0, "R7 plain plus set result");
        go(1, 1, ra(CL, 9), 32'h0F00_0000, 1, 1, ra(PL, 9), 32'h0FF0_0000, "R7 plain plus clear");
        go(1, 0, ra(PL, 9), 0, 0, 0, 0, 0, "R7 plain plus clear result");

        // R8 unmapped: error, zero data, no register changes
        go(1, 1, 16'h0040, 32'hDEAD_BEEF, 1, 1, 16'h300C, 32'hFFFF_FFFF, "R8 unmapped write");
        go(1, 0, 16'h3004, 0, 1, 0, 16'h0FFC, 0, "R8 unmapped read");
        go(1, 0, ra(PL, 0), 0, 1, 0, ra(PL, 3), 0, "R8 no change");

        // R9 upper and byte-lane address bits ignored
        go(1, 1, 16'hD012, 32'h0000_0C00, 0, 0, 0, 0, "R9 set with upper bits");
        go(0, 0, 0, 0, 1, 0, 16'h4011, 0, "R9 read with upper bits");

        // R6 random mix of all windows on both ports
        for (int i = 0; i < 400; i++) begin
            logic [15:0] x0, x1;
            x0 = 16'(($urandom % 4) << 12) | 16'(($urandom % 18) * 4);
            x1 = 16'(($urandom % 4) << 12) | 16'(($urandom % 18) * 4);
            if ($urandom % 8 != 0) begin
                x0[13:12] = 2'($urandom % 3);
                x1[13:12] = 2'($urandom % 3);
            end
            go($urandom % 4 != 0, $urandom % 2 == 1, x0, $urandom,
               $urandom % 4 != 0, $urandom % 2 == 1, x1, $urandom, "R6 random mix");
        end
        for (int r = 0; r < NREG; r += 2)
            go(1, 0, ra(PL, r), 0, 1, 0, ra(ST, r + 1), 0, "R6 final sweep");

        repeat (3) idle();
        #2;
        checks = checks + 1;
        if (sb0.size() != 0 || sb1.size() != 0) begin
            errors = errors + 1;
            $display("FAIL R4 missing responses: actual=%0d/%0d expected=0/0", sb0.size(), sb1.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule